// File: doc/BRIEF.md
# Flash Byte Program Engine

This engine writes a short run of bytes into a byte-wide flash device that sits behind a word-addressed bus. A separate two-bit lane register picks the byte within the word. The caller gives a start address and a requested length, then streams the data bytes over a ready/valid input. The length is clipped so that the run never crosses a 64 KiB block boundary and never exceeds the local replay buffer. Each accepted byte is kept in that buffer.

For every byte the engine does a dummy read and loads the lane register. It then issues the program command and the data to the word-aligned address, asks for status and polls until the device reports ready. It then returns the device to array-read mode. There are two recovery paths. A status poll that never sees ready makes the engine clear status and repeat the byte. A ready status that carries the program-error flag makes the engine clear status, wait, and retry, as long as the block deadline has not passed.

When every byte is programmed, the engine waits a settle time, reads the whole run back and compares it with the buffered copy. The result is a single-cycle done pulse together with the written count and an error code.

Top module: `fbp_engine`

## Requirements
- R1: The effective length is the smallest of the requested count, 0x10000 minus address bits [15:0], and BUF_DEPTH. Exactly that many bytes are taken from the input stream on a successful run.
- R2: Before each byte's program command, lane_val is loaded with address bits [1:0] via a lane_we pulse. The command byte 0x40 and the data byte are both written to the address with bits [1:0] forced to zero.
- R3: Each byte's bus sequence is, in this order: a read at 0x08000, the lane load, 0x40, the data, 0x70 written at 0x10000, status reads at 0x08000, and finally 0xFF written at 0x08000.
- R4: If BYTE_TMO+1 consecutive status reads show bit 7 clear, the engine writes 0x50 at 0x08000 and restarts the same byte from its dummy read, without taking a new input byte.
- R5: A ready status (bit 7 set) with bit 4 set makes the engine write 0x50 at 0x08000 after the 0xFF. If fewer than BLOCK_TMO cycles have passed since start, it idles RETRY_WAIT cycles and reprograms the same byte.
- R6: A program error seen after the BLOCK_TMO deadline ends the run with err_code 1 and written_count 0.
- R7: After programming, the engine waits SETTLE_WAIT cycles and then reads each byte back at its own address. The first mismatch ends the run with err_code 2 and written_count 0.
- R8: A run that verifies ends with err_code 0 and written_count equal to the effective length. A zero effective length finishes at once with count 0 and no bus traffic.
- R9: After reset, and after a reset in the middle of a run, busy, done, in_ready, lane_we, fl_rd and fl_wr are low, and written_count and err_code are zero. in_ready is high only while busy.
- R10: done is a one-cycle pulse. written_count and err_code are valid during the pulse and hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| start_addr | input | ADDR_W | Byte address of the first byte |
| req_count | input | 17 | Requested number of bytes |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Engine takes the input byte this cycle |
| lane_we | output | 1 | Load strobe for the byte-lane register |
| lane_val | output | 2 | Byte lane within the word |
| fl_rd | output | 1 | Flash read strobe; data is expected on fl_rdata the next cycle |
| fl_wr | output | 1 | Flash write strobe |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, one cycle after fl_rd |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| written_count | output | 17 | Bytes written and verified (0 on error) |
| err_code | output | 2 | 0 ok, 1 program deadline, 2 verify mismatch |

## Verification
A run's results are due on the done pulse. That pulse comes one cycle after the engine leaves its final bus action, which may be the last verify compare or the 0x50 write that closes a deadline failure. The length of a run depends on retries and status polls, so the bench does not count a fixed number of cycles. It waits on done at falling edges and samples written_count, err_code, the number of bytes handed over and the model's clear-status tally in that same half cycle. Bus order and addresses are checked by the flash model as each strobe arrives, registering on the edge at which the strobe is seen. Read data is returned one edge later, which matches the engine's one-cycle read latency.

// File: rtl/fbp_pkg.sv
// Shared types and command codes for the flash byte program engine.
// Assumes a byte-wide flash device with a 64 KiB block size.
package fbp_pkg;
    localparam int CNT_W = 17;

    localparam logic [7:0] CMD_PROG = 8'h40;
    localparam logic [7:0] CMD_STAT = 8'h70;
    localparam logic [7:0] CMD_CLR  = 8'h50;
    localparam logic [7:0] CMD_READ = 8'hFF;

    typedef enum logic [4:0] {
        S_IDLE, S_FETCH, S_DUMMY, S_LANE, S_CMD, S_DATA, S_STREQ,
        S_POLL_RD, S_POLL_CHK, S_RDMODE, S_CLR_TMO, S_CLR_ERR,
        S_RWAIT, S_SETTLE, S_VRD, S_VCHK, S_FIN
    } fbp_state_t;

    typedef enum logic [1:0] {
        FBP_OK         = 2'd0,
        FBP_ERR_PROG   = 2'd1,
        FBP_ERR_VERIFY = 2'd2
    } fbp_err_t;
endpackage

// File: rtl/fbp_span_clip.sv
// Computes the effective run length: the smallest of the request, the
// bytes left in the 64 KiB block, and the replay buffer capacity.
// Assumes CAP fits in 17 bits. Purely combinational.
module fbp_span_clip #(
    parameter int CAP = 16
) (
    input  logic [15:0]               addr_lo,
    input  logic [fbp_pkg::CNT_W-1:0] req,
    output logic [fbp_pkg::CNT_W-1:0] eff
);
    localparam int W = fbp_pkg::CNT_W;
    localparam logic [W-1:0] CAP_V = W'(CAP);

    logic [W-1:0] room;
    logic [W-1:0] lim;

    // Choose the tightest of the three limits.
    always_comb begin
        room = 17'h10000 - {1'b0, addr_lo};
        lim  = (req < room) ? req : room;
        eff  = (lim < CAP_V) ? lim : CAP_V;
    end
endmodule

// File: rtl/fbp_byte_store.sv
// Small replay buffer: holds each accepted byte so that it can be
// programmed again on retry and compared during read-back.
// Assumes DEPTH is at least 2. Read is combinational.
module fbp_byte_store #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    // Store one byte per accepted handshake.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fbp_tick_counter.sv
// Saturating cycle counter. It raises reached once LIMIT increments have
// been counted since the last clear. Assumes LIMIT >= 1.
module fbp_tick_counter #(
    parameter int LIMIT = 16,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic reached
);
    logic [W-1:0] cnt;

    assign reached = (cnt >= W'(LIMIT));

    // Count up to the limit and stay there until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && !reached) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fbp_engine.sv
// Flash byte program engine (top). It programs a clipped run of streamed
// bytes, one bus action per cycle: a dummy read, the lane load, the
// command, the data, the status request, status polls and a return to
// read mode. It retries on a stuck busy status or a device-reported
// program error, then reads the run back and compares it with the
// buffered copy. Assumes ADDR_W >= 17 and that fl_rdata is valid one
// cycle after fl_rd.
module fbp_engine
    import fbp_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int BUF_DEPTH   = 16,
    parameter int BYTE_TMO    = 1000,
    parameter int RETRY_WAIT  = 500,
    parameter int SETTLE_WAIT = 500,
    parameter int BLOCK_TMO   = 30000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [16:0]       req_count,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              lane_we,
    output logic [1:0]        lane_val,
    output logic              fl_rd,
    output logic              fl_wr,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic [7:0]        fl_rdata,
    output logic              busy,
    output logic              done,
    output logic [16:0]       written_count,
    output logic [1:0]        err_code
);
    localparam int IDX_W = $clog2(BUF_DEPTH);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(32'h0_8000);
    localparam logic [ADDR_W-1:0] ADDR_SREQ = ADDR_W'(32'h1_0000);

    fbp_state_t        state;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  total;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  eff_len;
    logic              stat_err;
    fbp_err_t          res;
    fbp_err_t          err_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] word_addr;
    logic [7:0]        buf_rd;
    logic              last;
    logic              byte_exp, blk_exp, retry_exp, settle_exp;

    assign cur_addr  = base + ADDR_W'(idx);
    assign word_addr = {cur_addr[ADDR_W-1:2], 2'b00};
    assign last      = (idx == total - 1'b1);
    assign busy      = (state != S_IDLE);
    assign in_ready  = (state == S_FETCH);
    assign err_code  = err_q;

    fbp_span_clip #(.CAP(BUF_DEPTH)) u_clip (
        .addr_lo (start_addr[15:0]),
        .req     (req_count),
        .eff     (eff_len)
    );

    fbp_byte_store #(.DEPTH(BUF_DEPTH)) u_store (
        .clk   (clk),
        .we    (in_ready && in_valid),
        .waddr (idx[IDX_W-1:0]),
        .wdata (in_data),
        .raddr (idx[IDX_W-1:0]),
        .rdata (buf_rd)
    );

    fbp_tick_counter #(.LIMIT(BYTE_TMO)) u_byte_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr(state == S_STREQ), .inc(state == S_POLL_CHK), .reached(byte_exp)
    );

    fbp_tick_counter #(.LIMIT(BLOCK_TMO)) u_blk_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr(state == S_IDLE), .inc(1'b1), .reached(blk_exp)
    );

    fbp_tick_counter #(.LIMIT(RETRY_WAIT)) u_retry_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr(state != S_RWAIT), .inc(1'b1), .reached(retry_exp)
    );

    fbp_tick_counter #(.LIMIT(SETTLE_WAIT)) u_settle_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr(state != S_SETTLE), .inc(1'b1), .reached(settle_exp)
    );

    // Sequencer: walks each byte through program, recovery and verify.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= S_IDLE;
            base          <= '0;
            total         <= '0;
            idx           <= '0;
            stat_err      <= 1'b0;
            res           <= FBP_OK;
            err_q         <= FBP_OK;
            done          <= 1'b0;
            written_count <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        base  <= start_addr;
                        total <= eff_len;
                        idx   <= '0;
                        res   <= FBP_OK;
                        state <= (eff_len == '0) ? S_FIN : S_FETCH;
                    end
                end
                S_FETCH:   if (in_valid) state <= S_DUMMY;
                S_DUMMY:   state <= S_LANE;
                S_LANE:    state <= S_CMD;
                S_CMD:     state <= S_DATA;
                S_DATA:    state <= S_STREQ;
                S_STREQ:   state <= S_POLL_RD;
                S_POLL_RD: state <= S_POLL_CHK;
                S_POLL_CHK: begin
                    if (fl_rdata[7]) begin
                        stat_err <= fl_rdata[4];
                        state    <= S_RDMODE;
                    end else if (byte_exp) begin
                        state <= S_CLR_TMO;
                    end else begin
                        state <= S_POLL_RD;
                    end
                end
                S_RDMODE: begin
                    if (stat_err) begin
                        state <= S_CLR_ERR;
                    end else if (last) begin
                        idx   <= '0;
                        state <= S_SETTLE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_FETCH;
                    end
                end
                S_CLR_TMO: state <= S_DUMMY;
                S_CLR_ERR: begin
                    if (blk_exp) begin
                        res   <= FBP_ERR_PROG;
                        state <= S_FIN;
                    end else begin
                        state <= S_RWAIT;
                    end
                end
                S_RWAIT:  if (retry_exp) state <= S_DUMMY;
                S_SETTLE: if (settle_exp) state <= S_VRD;
                S_VRD:    state <= S_VCHK;
                S_VCHK: begin
                    if (fl_rdata != buf_rd) begin
                        res   <= FBP_ERR_VERIFY;
                        state <= S_FIN;
                    end else if (last) begin
                        state <= S_FIN;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_VRD;
                    end
                end
                S_FIN: begin
                    done          <= 1'b1;
                    written_count <= (res == FBP_OK) ? total : '0;
                    err_q         <= res;
                    state         <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Bus decode: one flash or lane action per state.
    always_comb begin
        fl_rd    = 1'b0;
        fl_wr    = 1'b0;
        fl_addr  = ADDR_STAT;
        fl_wdata = 8'h00;
        lane_we  = 1'b0;
        lane_val = cur_addr[1:0];
        case (state)
            S_DUMMY:   fl_rd = 1'b1;
            S_LANE:    lane_we = 1'b1;
            S_CMD:     begin fl_wr = 1'b1; fl_addr = word_addr; fl_wdata = CMD_PROG; end
            S_DATA:    begin fl_wr = 1'b1; fl_addr = word_addr; fl_wdata = buf_rd; end
            S_STREQ:   begin fl_wr = 1'b1; fl_addr = ADDR_SREQ; fl_wdata = CMD_STAT; end
            S_POLL_RD: fl_rd = 1'b1;
            S_RDMODE:  begin fl_wr = 1'b1; fl_wdata = CMD_READ; end
            S_CLR_TMO,
            S_CLR_ERR: begin fl_wr = 1'b1; fl_wdata = CMD_CLR; end
            S_VRD:     begin fl_rd = 1'b1; fl_addr = cur_addr; end
            default:   ;
        endcase
    end

    // R1
    clip_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (({2'b00, base[15:0]} + {1'b0, written_count}) <= 18'h10000)
                 && (written_count <= 17'(BUF_DEPTH)));

    // R6
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 2'd0) |-> (written_count == '0));

    // R3
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_rd && fl_wr));

    // R4
    stuck_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POLL_CHK && !fl_rdata[7] && byte_exp)
        |=> (fl_wr && fl_wdata == CMD_CLR && fl_addr == ADDR_STAT));

    // R5
    retry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLR_ERR && !blk_exp) |=> (!done && busy));

    // R9
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/fbp_engine_tb.sv
module fbp_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 20;
    localparam int NV  = 10;

    typedef struct packed {
        logic [19:0] addr;
        logic [16:0] req;
        logic [15:0] einj;
        logic [7:0]  stuck;
        logic        corrupt;
        logic [16:0] ecnt;
        logic [1:0]  eerr;
        logic [16:0] etaken;
        logic [7:0]  eclr;
        logic        chkclr;
    } vec_t;

    // addr, req, errors injected, stuck reads, corrupt, exp count, exp err, exp taken, exp clears, check clears
    localparam vec_t VECS [NV] = '{
        '{20'h10100, 17'd8,  16'd0,    8'd0,   1'b0, 17'd8,  2'd0, 17'd8,  8'd0, 1'b1},
        '{20'h10203, 17'd5,  16'd0,    8'd0,   1'b0, 17'd5,  2'd0, 17'd5,  8'd0, 1'b1},
        '{20'h1FFFC, 17'd10, 16'd0,    8'd0,   1'b0, 17'd4,  2'd0, 17'd4,  8'd0, 1'b1},
        '{20'h10400, 17'd40, 16'd0,    8'd0,   1'b0, 17'd16, 2'd0, 17'd16, 8'd0, 1'b1},
        '{20'h10500, 17'd6,  16'd2,    8'd0,   1'b0, 17'd6,  2'd0, 17'd6,  8'd2, 1'b1},
        '{20'h10600, 17'd4,  16'd0,    8'd100, 1'b0, 17'd4,  2'd0, 17'd4,  8'd1, 1'b1},
        '{20'h10700, 17'd4,  16'd0,    8'd0,   1'b1, 17'd0,  2'd2, 17'd4,  8'd0, 1'b1},
        '{20'h10800, 17'd4,  16'd1000, 8'd0,   1'b0, 17'd0,  2'd1, 17'd1,  8'd0, 1'b0},
        '{20'h10900, 17'd0,  16'd0,    8'd0,   1'b0, 17'd0,  2'd0, 17'd0,  8'd0, 1'b1},
        '{20'h1FFFF, 17'd3,  16'd0,    8'd0,   1'b0, 17'd1,  2'd0, 17'd1,  8'd0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [16:0] req_count = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_data;
    logic in_ready, lane_we, fl_rd, fl_wr, busy, done;
    logic [1:0] lane_val, err_code;
    logic [AW-1:0] fl_addr;
    logic [7:0] fl_wdata;
    logic [7:0] fl_rdata = 8'h00;
    logic [16:0] written_count;

    int n_chk = 0;
    int n_bad = 0;
    int cur_v = 0;

    // model configuration, loaded on mdl_clr
    logic mdl_clr = 1'b0;
    int cfg_err = 0;
    int cfg_stuck = 0;
    logic cfg_corrupt = 1'b0;
    logic [AW-1:0] cfg_caddr = '0;

    // model state
    logic [7:0] mem [4096];
    logic prog_pend, stat_mode, sr_err, seen_dummy, lane_fresh;
    logic [1:0] lane_q;
    int busy_left, err_left, stuck_once, clr_cnt, proto_bad, taken;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] pat(input int v, input int k);
        return 8'(v * 37 + k * 11 + 5);
    endfunction

    assign in_data = pat(cur_v, taken);

    fbp_engine #(
        .ADDR_W(AW), .BUF_DEPTH(16), .BYTE_TMO(16), .RETRY_WAIT(6),
        .SETTLE_WAIT(5), .BLOCK_TMO(500)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .req_count(req_count), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .lane_we(lane_we), .lane_val(lane_val),
        .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .busy(busy), .done(done),
        .written_count(written_count), .err_code(err_code)
    );

    // Flash device model with fault injection and bus-order checks.
    always @(posedge clk) begin
        if (mdl_clr) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 8'hFF;
            prog_pend <= 1'b0; stat_mode <= 1'b0; sr_err <= 1'b0;
            seen_dummy <= 1'b0; lane_fresh <= 1'b0; lane_q <= 2'd0;
            busy_left <= 0; err_left <= cfg_err; stuck_once <= cfg_stuck;
            clr_cnt <= 0; proto_bad <= 0; taken <= 0;
        end else begin
            if (in_valid && in_ready) taken <= taken + 1;
            if (lane_we) begin lane_q <= lane_val; lane_fresh <= 1'b1; end
            if (fl_rd) begin
                if (fl_addr == 20'h08000) seen_dummy <= 1'b1;
                if (stat_mode) begin
                    fl_rdata <= {(busy_left == 0), 2'b00, sr_err, 4'h0};
                    if (busy_left > 0) busy_left <= busy_left - 1;
                end else if (cfg_corrupt && fl_addr == cfg_caddr) begin
                    fl_rdata <= ~mem[fl_addr[11:0]];
                end else begin
                    fl_rdata <= mem[fl_addr[11:0]];
                end
            end
            if (fl_wr) begin
                if (prog_pend) begin
                    prog_pend <= 1'b0; stat_mode <= 1'b1;
                    busy_left <= stuck_once; stuck_once <= 0;
                    if (fl_addr[1:0] != 2'd0) proto_bad <= proto_bad + 1;
                    if (err_left > 0) begin
                        err_left <= err_left - 1; sr_err <= 1'b1;
                    end else begin
                        mem[{fl_addr[11:2], lane_q}] <= fl_wdata;
                    end
                end else begin
                    case (fl_wdata)
                        8'h40: begin
                            prog_pend <= 1'b1; seen_dummy <= 1'b0; lane_fresh <= 1'b0;
                            if (fl_addr[1:0] != 2'd0 || !seen_dummy || !lane_fresh)
                                proto_bad <= proto_bad + 1;
                        end
                        8'h70: begin
                            stat_mode <= 1'b1;
                            if (fl_addr != 20'h10000) proto_bad <= proto_bad + 1;
                        end
                        8'hFF: begin
                            stat_mode <= 1'b0;
                            if (fl_addr != 20'h08000) proto_bad <= proto_bad + 1;
                        end
                        8'h50: begin
                            sr_err <= 1'b0; clr_cnt <= clr_cnt + 1;
                            if (fl_addr != 20'h08000) proto_bad <= proto_bad + 1;
                        end
                        default: proto_bad <= proto_bad + 1;
                    endcase
                end
            end
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic load_model(input int v);
        @(negedge clk);
        cur_v = v;
        cfg_err = int'(VECS[v].einj);
        cfg_stuck = int'(VECS[v].stuck);
        cfg_corrupt = VECS[v].corrupt;
        cfg_caddr = VECS[v].addr + 20'd1;
        mdl_clr = 1'b1;
        @(negedge clk);
        mdl_clr = 1'b0;
    endtask

    task automatic launch(input int v);
        start_addr = VECS[v].addr;
        req_count = VECS[v].req;
        in_valid = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        ok = done;
    endtask

    initial begin
        bit got;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !in_ready, "R9 reset busy/done/ready", {busy, done, in_ready}, 0);
        chk(!fl_rd && !fl_wr && !lane_we, "R9 reset bus strobes", {fl_rd, fl_wr, lane_we}, 0);
        chk(written_count == 0 && err_code == 0, "R9 reset results", written_count, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            load_model(v);
            launch(v);
            wait_done(got);
            chk(got, $sformatf("R10 done pulse v%0d", v), got, 1);
            // R1 R8 count, R6 R7 error code
            chk(written_count == VECS[v].ecnt, $sformatf("R1/R8 count v%0d", v),
                written_count, VECS[v].ecnt);
            chk(err_code == VECS[v].eerr, $sformatf("R6/R7 err v%0d", v),
                err_code, VECS[v].eerr);
            chk(taken == int'(VECS[v].etaken), $sformatf("R1 bytes taken v%0d", v),
                taken, VECS[v].etaken);
            // R3 R2 bus order and addressing
            chk(proto_bad == 0, $sformatf("R3 bus order v%0d", v), proto_bad, 0);
            if (VECS[v].chkclr)
                chk(clr_cnt == int'(VECS[v].eclr), $sformatf("R4/R5 clears v%0d", v),
                    clr_cnt, VECS[v].eclr);
            if (VECS[v].eerr == 2'd0) begin
                int bad = 0;
                for (int k = 0; k < int'(VECS[v].ecnt); k++)
                    if (mem[12'(VECS[v].addr + 20'(k))] != pat(v, k)) bad++;
                chk(bad == 0, $sformatf("R2 lane placement v%0d", v), bad, 0);
            end
            @(negedge clk);
            // R10: single-cycle pulse, results held
            chk(!done && written_count == VECS[v].ecnt, $sformatf("R10 hold v%0d", v),
                {done, written_count}, VECS[v].ecnt);
            in_valid = 1'b0;
        end

        // R9: reset in the middle of a run
        load_model(3);
        launch(3);
        repeat (20) @(negedge clk);
        chk(busy, "R9 busy mid-run", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !in_ready && !fl_rd && !fl_wr && !lane_we, "R9 mid-run reset",
            {busy, in_ready, fl_rd, fl_wr, lane_we}, 0);
        chk(written_count == 0 && err_code == 0, "R9 mid-run reset results", written_count, 0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule